// File: doc/BRIEF.md
# I2C Host Command-Bit Sequencer

This block is the host side of a two-wire serial bus engine. Software controls it through an 8-bit control register. Five of its bits are single-action commands: Start, Repeated Start, Stop, Acknowledge and Receive-byte. Setting one of them asks the engine for exactly one bus event. The engine runs that event on the open-drain clock and data lines and clears the bit itself when the event is over. A write to the transmit buffer while the engine is idle sends one byte. The acknowledge that comes back is recorded in a status bit that only hardware can change. A received byte goes to a read buffer and sets a full flag.

Bus timing comes from an internal baud tick. Each step of a bus sequence advances on one tick. The time that a Start holds the data line low with the clock high can be set from a port. While a sequence is running, the engine rejects new command bits and transmit-buffer writes. Nothing is held back to run later. The host steps the bus one event at a time and gets a one-cycle interrupt pulse at the end of each event. When the host-mode input is low, the engine is in client mode. Bit 0 then holds a clock-stretch enable and causes no bus activity.

Top module: `i2cseq_top`

## Requirements
- R1: After reset the control register reads 0x00. Both line enables are 0 (lines released). `busy`, `rx_full` and `irq` are 0.
- R2: In host mode, writing control bit 0 = 1 makes SDA fall while SCL is high. SDA is then held low with SCL high for exactly `hold_ticks` baud ticks, with a minimum of one, before SCL is pulled low. When the sequence ends, bit 0 reads 0 and both lines stay pulled low.
- R3: Writing control bit 1 = 1 first releases SDA while SCL is low and then releases SCL. It then makes SDA fall while SCL is high, with the same hold as in R2. When the sequence ends, bit 1 reads 0.
- R4: Writing control bit 2 = 1 pulls SDA low while SCL is low, then releases SCL. SDA then rises while SCL is high. At the end both lines are released and bit 2 reads 0.
- R5: A write with `wr_sel` = 1 while the engine is idle in host mode sends the 8 data bits MSB first, one bit per SCL high phase. SDA changes only while SCL is low. On the ninth clock SDA is released and sampled into control bit 6: 1 means no acknowledge, 0 means acknowledged.
- R6: Writing control bit 3 = 1 gives 8 SCL pulses with SDA released. The sampled bits go MSB first into `rx_data`, `rx_full` is set to 1 and bit 3 reads 0. A pulse on `rx_clr` clears `rx_full`.
- R7: Writing control bit 4 = 1 gives one SCL pulse. During it, SDA is pulled low if control bit 5 is 0 (ACK) and released if bit 5 is 1 (NACK). Bit 4 then reads 0, and bit 5 keeps its value.
- R8: While `busy` is 1, writes that set command bits (bits 4 to 0) and transmit-buffer writes are ignored. The register does not take these bits, and no extra sequence runs after the current one ends.
- R9: Each finished sequence gives exactly one `irq` pulse, one clock cycle long.
- R10: If another device holds SCL low after the engine releases it, the engine waits. It samples no bit and gives no SCL high phase until the line really goes high. The byte sent is unchanged.
- R11: With `host_mode` = 0, writes store bit 0 as a clock-stretch enable and store bit 7. Both read back as written. There is no bus activity and `busy` stays 0.
- R12: If one idle host-mode write sets several command bits, only the one with the highest priority is accepted. The order is Start, Repeated Start, Stop, Acknowledge, Receive. The other bits are not stored.
- R13: Software writes to control bit 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 = host mode, 0 = client mode |
| hold_ticks | input | HOLD_W | Baud ticks of Start hold (0 treated as 1) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = transmit buffer |
| wr_data | input | 8 | Write data |
| rx_clr | input | 1 | Clears the receive-full flag |
| ctrl_q | output | 8 | Control register value |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Received byte waiting |
| busy | output | 1 | Sequence in progress |
| irq | output | 1 | One-cycle pulse at end of each sequence |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |

## Verification
The single-command check on the control register assumes two things. First, `host_mode` changes only while all command bits are clear. Second, bit 0 is never left set from client mode when the block returns to host mode. The bench clears the register before it switches modes. The bus-level checks assume that SCL and SDA are wired-AND lines. Devices other than the host change SDA only after a falling SCL and only stretch SCL while it is low. The bench line model follows these rules: its client pull-downs change on SCL falling edges, and its stretch is asserted only while the host holds SCL low.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  // Control register field positions (bit 0 doubles as stretch enable in client mode)
  localparam int F_START  = 0;
  localparam int F_RSTART = 1;
  localparam int F_STOP   = 2;
  localparam int F_RECV   = 3;
  localparam int F_ACKGO  = 4;
  localparam int F_ACKVAL = 5;
  localparam int F_ACKRX  = 6;
  localparam int F_GCALL  = 7;
  localparam int CMD_W    = 5;

  typedef enum logic [2:0] {
    OP_START, OP_RSTART, OP_STOP, OP_ACK, OP_RX, OP_TX
  } op_t;

  typedef enum logic [3:0] {
    E_IDLE, E_ST_REL, E_ST_HOLD, E_RS_LO, E_RS_UP,
    E_SP_LO, E_SP_UP, E_SP_WAIT,
    E_B_LO, E_B_UP, E_B_HI, E_B_DN, E_B_END
  } est_t;

endpackage

// File: rtl/i2cseq_tick.sv
module i2cseq_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= (cnt_q == LAST);
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R9
endmodule

// File: rtl/i2cseq_engine.sv
module i2cseq_engine
  import i2cseq_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              go,
  input  op_t               op,
  input  logic [7:0]        tx_byte,
  input  logic              ack_val,
  input  logic [HOLD_W-1:0] hold,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              done,
  output logic [7:0]        sh_byte,
  output logic              ack_bit
);
  localparam logic [3:0] TX_LAST = 4'd8;
  localparam logic [3:0] RX_LAST = 4'd7;

  est_t              st_q;
  op_t               op_q;
  logic [3:0]        idx_q;
  logic [HOLD_W-1:0] cnt_q;
  logic              ackv_q;
  logic              drive_low;
  logic [3:0]        last_idx;

  always_comb begin
    unique case (op_q)
      OP_TX:   last_idx = TX_LAST;
      OP_RX:   last_idx = RX_LAST;
      default: last_idx = 4'd0;
    endcase
  end

  always_comb begin
    unique case (op_q)
      OP_TX:   drive_low = (idx_q < TX_LAST) ? ~sh_byte[7] : 1'b0;
      OP_ACK:  drive_low = ~ackv_q;
      default: drive_low = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= E_IDLE;
      op_q    <= OP_START;
      idx_q   <= '0;
      cnt_q   <= '0;
      ackv_q  <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      done    <= 1'b0;
      sh_byte <= '0;
      ack_bit <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        E_IDLE: if (go) begin
          op_q   <= op;
          idx_q  <= '0;
          ackv_q <= ack_val;
          if (op == OP_TX) sh_byte <= tx_byte;
          unique case (op)
            OP_START:  begin scl_oe <= 1'b0; sda_oe <= 1'b0; st_q <= E_ST_REL; end
            OP_RSTART: st_q <= E_RS_LO;
            OP_STOP:   st_q <= E_SP_LO;
            default:   st_q <= E_B_LO;
          endcase
        end
        E_ST_REL: if (tick && scl_in && sda_in) begin
          sda_oe <= 1'b1;
          cnt_q  <= HOLD_W'(1);
          st_q   <= E_ST_HOLD;
        end
        E_ST_HOLD: if (tick) begin
          if (cnt_q >= hold) begin
            scl_oe <= 1'b1;
            done   <= 1'b1;
            st_q   <= E_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        E_RS_LO: if (tick) begin
          scl_oe <= 1'b1;
          sda_oe <= 1'b0;
          st_q   <= E_RS_UP;
        end
        E_RS_UP: if (tick) begin
          scl_oe <= 1'b0;
          st_q   <= E_ST_REL;
        end
        E_SP_LO: if (tick) begin
          scl_oe <= 1'b1;
          sda_oe <= 1'b1;
          st_q   <= E_SP_UP;
        end
        E_SP_UP: if (tick) begin
          scl_oe <= 1'b0;
          st_q   <= E_SP_WAIT;
        end
        E_SP_WAIT: if (tick && scl_in) begin
          sda_oe <= 1'b0;
          done   <= 1'b1;
          st_q   <= E_IDLE;
        end
        E_B_LO: if (tick) begin
          scl_oe <= 1'b1;
          sda_oe <= drive_low;
          st_q   <= E_B_UP;
        end
        E_B_UP: if (tick) begin
          scl_oe <= 1'b0;
          st_q   <= E_B_HI;
        end
        E_B_HI: if (tick && scl_in) begin
          if (op_q == OP_TX && idx_q == TX_LAST) ack_bit <= sda_in;
          else                                   sh_byte <= {sh_byte[6:0], sda_in};
          st_q <= E_B_DN;
        end
        E_B_DN: if (tick) begin
          scl_oe <= 1'b1;
          if (idx_q == last_idx) st_q <= E_B_END;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= E_B_LO;
          end
        end
        E_B_END: if (tick) begin
          sda_oe <= 1'b0;
          done   <= 1'b1;
          st_q   <= E_IDLE;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  AST_SDA_STILL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st_q == E_B_HI && !scl_oe) |=> $stable(sda_oe)); // R5
  AST_START_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == E_ST_HOLD) |-> (sda_oe && !scl_oe)); // R2
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_STOP) |-> (!sda_oe && !scl_oe)); // R4
  AST_NO_SAMPLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (st_q == E_B_HI && !scl_in) |=> (st_q == E_B_HI)); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (st_q == E_IDLE)); // R9
endmodule

// File: rtl/i2cseq_regs.sv
module i2cseq_regs
  import i2cseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       host_mode,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rx_clr,
  input  logic       eng_done,
  input  logic [7:0] eng_byte,
  input  logic       eng_ack,
  output logic [7:0] ctrl_q,
  output logic [7:0] txbuf_q,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       busy,
  output logic       irq,
  output logic       go,
  output op_t        cur_op
);
  logic [CMD_W-1:0] pick_bits;
  logic             pick_any;
  op_t              pick_op;
  logic             wr_ctrl, wr_tx;

  assign wr_ctrl = wr_en && !wr_sel;
  assign wr_tx   = wr_en &&  wr_sel;

  // Priority: start > repeated start > stop > acknowledge > receive
  always_comb begin
    pick_bits = '0;
    pick_any  = 1'b1;
    pick_op   = OP_START;
    if      (wr_data[F_START])  begin pick_bits[F_START]  = 1'b1; pick_op = OP_START;  end
    else if (wr_data[F_RSTART]) begin pick_bits[F_RSTART] = 1'b1; pick_op = OP_RSTART; end
    else if (wr_data[F_STOP])   begin pick_bits[F_STOP]   = 1'b1; pick_op = OP_STOP;   end
    else if (wr_data[F_ACKGO])  begin pick_bits[F_ACKGO]  = 1'b1; pick_op = OP_ACK;    end
    else if (wr_data[F_RECV])   begin pick_bits[F_RECV]   = 1'b1; pick_op = OP_RX;     end
    else                        pick_any = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      txbuf_q <= '0;
      rx_data <= '0;
      rx_full <= 1'b0;
      busy    <= 1'b0;
      irq     <= 1'b0;
      go      <= 1'b0;
      cur_op  <= OP_START;
    end else begin
      go  <= 1'b0;
      irq <= 1'b0;
      if (wr_ctrl) begin
        ctrl_q[F_GCALL]  <= wr_data[F_GCALL];
        ctrl_q[F_ACKVAL] <= wr_data[F_ACKVAL];
        if (!host_mode) begin
          ctrl_q[F_START] <= wr_data[F_START];
        end else if (!busy && pick_any) begin
          ctrl_q[CMD_W-1:0] <= pick_bits;
          cur_op <= pick_op;
          go     <= 1'b1;
          busy   <= 1'b1;
        end
      end else if (wr_tx && host_mode && !busy) begin
        txbuf_q <= wr_data;
        cur_op  <= OP_TX;
        go      <= 1'b1;
        busy    <= 1'b1;
      end
      if (rx_clr) rx_full <= 1'b0;
      if (eng_done) begin
        busy <= 1'b0;
        irq  <= 1'b1;
        ctrl_q[CMD_W-1:0] <= '0;
        if (cur_op == OP_TX) ctrl_q[F_ACKRX] <= eng_ack;
        if (cur_op == OP_RX) begin
          rx_data <= eng_byte;
          rx_full <= 1'b1;
        end
      end
    end
  end

  AST_CMD_LOCK: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_done) |=> $stable(ctrl_q[CMD_W-1:0])); // R8
  AST_TX_LOCK: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(txbuf_q)); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R9
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
    host_mode |-> $onehot0(ctrl_q[CMD_W-1:0])); // R12
  AST_ACKRX_HW: assert property (@(posedge clk) disable iff (rst)
    !eng_done |=> $stable(ctrl_q[F_ACKRX])); // R13
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
  import i2cseq_pkg::*;
#(
  parameter int TICK_DIV = 8,
  parameter int HOLD_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_mode,
  input  logic [HOLD_W-1:0] hold_ticks,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              rx_clr,
  output logic [7:0]        ctrl_q,
  output logic [7:0]        rx_data,
  output logic              rx_full,
  output logic              busy,
  output logic              irq,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic       tick, go, eng_done, eng_ack;
  logic [7:0] eng_byte, txbuf;
  op_t        cur_op;

  i2cseq_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  i2cseq_regs u_regs (
    .clk(clk), .rst(rst), .host_mode(host_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rx_clr(rx_clr),
    .eng_done(eng_done), .eng_byte(eng_byte), .eng_ack(eng_ack),
    .ctrl_q(ctrl_q), .txbuf_q(txbuf), .rx_data(rx_data), .rx_full(rx_full),
    .busy(busy), .irq(irq), .go(go), .cur_op(cur_op)
  );

  i2cseq_engine #(.HOLD_W(HOLD_W)) u_eng (
    .clk(clk), .rst(rst), .tick(tick), .go(go), .op(cur_op),
    .tx_byte(txbuf), .ack_val(ctrl_q[F_ACKVAL]), .hold(hold_ticks),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(eng_done), .sh_byte(eng_byte), .ack_bit(eng_ack)
  );

  AST_CLIENT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!host_mode && !busy) |=> !busy); // R11
endmodule

// File: tb/i2cseq_top_test.sv
module i2cseq_top_test;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_mode = 1'b1;
  logic [3:0] hold_ticks = 4'd2;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rx_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_q, rx_data;
  logic       rx_full, busy, irq, scl_oe, sda_oe;
  logic       scl_line, sda_line, slave_pull;
  logic       stretch = 1'b0;
  logic [1:0] sl_mode = 2'd0;    // 0 none, 1 send byte, 2 ack on ninth clock
  logic [7:0] sl_byte = 8'h00;
  int         sl_base = 0;

  int errors = 0, checks = 0;
  int starts = 0, stops = 0, rises = 0, falls = 0, irqs = 0, lowhigh = 0;
  logic [8:0] cap = '0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;

  always #10 clk = ~clk;

  assign scl_line = !scl_oe && !stretch;
  assign sda_line = !sda_oe && !slave_pull;

  always_comb begin
    int rel;
    rel = falls - sl_base;
    slave_pull = 1'b0;
    if (sl_mode == 2'd1 && rel >= 0 && rel < 8) slave_pull = ~sl_byte[3'(7 - rel)];
    else if (sl_mode == 2'd2 && rel == 8)       slave_pull = 1'b1;
  end

  i2cseq_top uut (
    .clk(clk), .rst(rst), .host_mode(host_mode), .hold_ticks(hold_ticks),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rx_clr(rx_clr),
    .ctrl_q(ctrl_q), .rx_data(rx_data), .rx_full(rx_full), .busy(busy), .irq(irq),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (scl_line && prev_scl && prev_sda && !sda_line) starts++;
      if (scl_line && prev_scl && !prev_sda && sda_line) stops++;
      if (scl_line && !sda_line) lowhigh++;
      if (scl_line && !prev_scl) begin rises++; cap <= {cap[7:0], sda_line}; end
      if (!scl_line && prev_scl) falls++;
      if (irq) irqs++;
    end
    prev_scl <= scl_line;
    prev_sda <= sda_line;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 8000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  int s0, p0, r0, q0, l0;
  task automatic snap();
    s0 = starts; p0 = stops; r0 = rises; q0 = irqs; l0 = lowhigh;
    sl_base = falls;
  endtask

  task automatic t_reset();
    check(ctrl_q == 8'h00, "R1 ctrl", ctrl_q, 0);
    check(!scl_oe && !sda_oe && !busy && !rx_full && !irq, "R1 outputs",
          {scl_oe, sda_oe, busy, rx_full, irq}, 0);
  endtask

  task automatic t_client();
    host_mode = 1'b0;
    wr(1'b0, 8'h81);
    check(ctrl_q == 8'h81, "R11 stored", ctrl_q, 8'h81);
    repeat (100) @(negedge clk);
    check(!busy && !scl_oe && !sda_oe, "R11 no bus", {busy, scl_oe, sda_oe}, 0);
    wr(1'b0, 8'h00);
    host_mode = 1'b1;
  endtask

  task automatic t_ackrx_ro();
    wr(1'b0, 8'h40);
    check(ctrl_q[6] == 1'b0, "R13 read-only", ctrl_q[6], 0);
  endtask

  task automatic t_start();
    hold_ticks = 4'd2; snap();
    wr(1'b0, 8'h01); wait_idle();
    check(starts - s0 == 1, "R2 start seen", starts - s0, 1);
    check(lowhigh - l0 == 2 * DIV, "R2 hold", lowhigh - l0, 2 * DIV);
    check(ctrl_q[0] == 1'b0, "R2 cleared", ctrl_q[0], 0);
    check(scl_oe && sda_oe, "R2 lines low", {scl_oe, sda_oe}, 3);
    check(irqs - q0 == 1, "R9 one irq", irqs - q0, 1);
  endtask

  task automatic t_tx(input logic [7:0] b, input bit ack);
    sl_mode = ack ? 2'd2 : 2'd0; snap();
    wr(1'b1, b); wait_idle();
    check(cap[8:1] == b, "R5 byte", cap[8:1], b);
    check(rises - r0 == 9, "R5 nine clocks", rises - r0, 9);
    check(ctrl_q[6] == !ack, "R5 ack status", ctrl_q[6], !ack);
    check(irqs - q0 == 1, "R9 one irq", irqs - q0, 1);
    sl_mode = 2'd0;
  endtask

  task automatic t_rx();
    sl_mode = 2'd1; sl_byte = 8'hC3; snap();
    wr(1'b0, 8'h08); wait_idle();
    check(rx_data == 8'hC3, "R6 data", rx_data, 8'hC3);
    check(rx_full && ctrl_q[3] == 1'b0, "R6 full/clear", {rx_full, ctrl_q[3]}, 2);
    check(rises - r0 == 8, "R6 eight clocks", rises - r0, 8);
    sl_mode = 2'd0;
    @(negedge clk); rx_clr = 1'b1; @(negedge clk); rx_clr = 1'b0; @(negedge clk);
    check(!rx_full, "R6 rx_clr", rx_full, 0);
  endtask

  task automatic t_ack(input bit nack);
    snap();
    wr(1'b0, nack ? 8'h30 : 8'h10); wait_idle();
    check(rises - r0 == 1, "R7 one clock", rises - r0, 1);
    check(cap[0] == nack, "R7 sda value", cap[0], nack);
    check(ctrl_q[5:4] == {nack, 1'b0}, "R7 bits", ctrl_q[5:4], {nack, 1'b0});
  endtask

  task automatic t_rstart();
    hold_ticks = 4'd3; snap();
    wr(1'b0, 8'h02); wait_idle();
    check(starts - s0 == 1, "R3 start seen", starts - s0, 1);
    check(lowhigh - l0 == 3 * DIV, "R3 hold", lowhigh - l0, 3 * DIV);
    check(ctrl_q[1] == 1'b0, "R3 cleared", ctrl_q[1], 0);
  endtask

  task automatic t_stretch();
    snap();
    wr(1'b1, 8'h96);
    @(negedge clk); stretch = 1'b1;
    repeat (300) @(negedge clk);
    check(rises == r0 && busy, "R10 waits", rises - r0, 0);
    stretch = 1'b0;
    wait_idle();
    check(cap[8:1] == 8'h96, "R10 byte", cap[8:1], 8'h96);
  endtask

  task automatic t_lockout();
    snap();
    wr(1'b1, 8'h33);
    wr(1'b1, 8'hCC);
    wr(1'b0, 8'h04);
    check(ctrl_q[4:0] == 5'd0, "R8 cmd ignored", ctrl_q[4:0], 0);
    wait_idle();
    check(cap[8:1] == 8'h33, "R8 buffer kept", cap[8:1], 8'h33);
    repeat (400) @(negedge clk);
    check(!busy && stops == p0 && rises - r0 == 9, "R8 nothing queued",
          rises - r0, 9);
  endtask

  task automatic t_priority();
    hold_ticks = 4'd1; snap();
    wr(1'b0, 8'h06);
    check(ctrl_q[4:0] == 5'h02, "R12 one kept", ctrl_q[4:0], 2);
    wait_idle();
    check(starts - s0 == 1 && stops == p0, "R12 only rstart", stops - p0, 0);
  endtask

  task automatic t_stop();
    snap();
    wr(1'b0, 8'h04); wait_idle();
    check(stops - p0 == 1, "R4 stop seen", stops - p0, 1);
    check(!scl_oe && !sda_oe && ctrl_q[2] == 1'b0, "R4 released",
          {scl_oe, sda_oe, ctrl_q[2]}, 0);
    check(irqs - q0 == 1, "R9 one irq", irqs - q0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_client();
    t_ackrx_ro();
    t_start();
    t_tx(8'hA5, 1'b1);
    t_tx(8'h5A, 1'b0);
    t_rx();
    t_ack(1'b0);
    t_ack(1'b1);
    wr(1'b0, 8'h00);
    t_rstart();
    t_stretch();
    t_lockout();
    t_priority();
    t_stop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule